// File: doc/BRIEF.md
# Extended Galois Field Array Multiplier

This block multiplies two elements of the extension field GF(d^m). The characteristic d is an odd prime and the degree m is a small integer; both are parameters. An element is a polynomial of degree below m whose coefficients are residues mod d. Each coefficient is a digit of ceil(log2 d) bits. A monic polynomial of degree m is fixed at elaboration and supplies the modulus. Its m lower coefficients are a parameter vector; the leading 1 is implied.

The product is formed by a combinational array of rows, one row per digit of the second operand. The first row uses the most significant digit. Each row shifts the running sum up one degree and adds the first operand scaled by its B digit. The digit that would spill into degree m is cancelled in the same row. The row forms the coefficient f = (d - top) mod d, multiplies the modulus polynomial by f and adds the result back in. Every digit position is handled by a cell that computes a sum of two products plus an addend, reduced mod d.

The block is used in elliptic-curve datapaths and other field-arithmetic units. These need odd-characteristic fields, where a binary-field multiplier does not apply.

Top module: `gfx_array_mul`

## Requirements
- R1: Digit i of an operand or of the product sits at bits [i*PW +: PW] and holds the coefficient of x^i, where PW = ceil(log2 d); digit 0 is least significant.
- R2: For operands whose digits are all below d, the product equals the schoolbook polynomial product with coefficients mod d, reduced modulo x^m plus the parameter polynomial.
- R3: With valid operands, every product digit is below d.
- R4: If either operand is zero, the product is zero.
- R5: The element with digit 0 equal to 1 and all other digits 0 is an identity on either side.
- R6: A product that reaches degree m is folded back: x^(m-1) times x yields digit i = (d - c_i) mod d, where c_i is lower coefficient i of the modulus.
- R7: The product follows a change of the operands with no clock edge in between; the block holds no state.
- R8: The same array is correct for other characteristics and degrees: GF(3^2) modulo x^2+1 and GF(5^3) modulo x^3+x+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | DEG_M*ceil(log2 CHAR_D) | First operand, one digit per coefficient |
| opnd_b | input | DEG_M*ceil(log2 CHAR_D) | Second operand, one digit per coefficient |
| prod | output | DEG_M*ceil(log2 CHAR_D) | Reduced product, same digit layout |

## Verification
The product is due within the same evaluation as the operands, with zero cycles of latency. The bench changes the operands 2 ns after a falling clock edge and reads the product 2 ns later, so no rising edge falls between stimulus and sample. For R7, the operands change in the high phase of the clock and the product is read 1 ns later, which confirms that no register is involved. The GF(7^3) configuration is swept over every operand pair, GF(3^2) is swept fully, and GF(5^3) takes random pairs. Each result is compared with an arithmetic long-division model in the bench.

// File: rtl/gfx_pkg.sv
`timescale 1ns/1ps
package gfx_pkg;
  // Width of one coefficient digit for characteristic d.
  function automatic int digit_bits(input int d);
    return (d < 3) ? 1 : $clog2(d);
  endfunction

  // Width that holds addend + two digit products without loss.
  function automatic int mac_bits(input int d);
    return 2 * digit_bits(d) + 2;
  endfunction
endpackage

// File: rtl/gfx_mac_cell.sv
`timescale 1ns/1ps
// One digit position: (acc + mx*my + rf*rp) mod d.
module gfx_mac_cell
  import gfx_pkg::*;
#(
  parameter int CHAR_D = 7,
  localparam int PW = digit_bits(CHAR_D)
) (
  input  logic [PW-1:0] acc_i,
  input  logic [PW-1:0] mx_i,
  input  logic [PW-1:0] my_i,
  input  logic [PW-1:0] rf_i,
  input  logic [PW-1:0] rp_i,
  output logic [PW-1:0] dig_o
);
  localparam int AW = mac_bits(CHAR_D);
  localparam logic [AW-1:0] MODV = AW'(CHAR_D);

  logic [AW-1:0] total;

  always_comb begin
    total = AW'(acc_i) + AW'(mx_i) * AW'(my_i) + AW'(rf_i) * AW'(rp_i);
    dig_o = PW'(total % MODV);
  end
endmodule

// File: rtl/gfx_neg_digit.sv
`timescale 1ns/1ps
// Additive inverse of a residue: (d - g) mod d, for g < d.
module gfx_neg_digit
  import gfx_pkg::*;
#(
  parameter int CHAR_D = 7,
  localparam int PW = digit_bits(CHAR_D)
) (
  input  logic [PW-1:0] g_i,
  output logic [PW-1:0] f_o
);
  localparam logic [PW-1:0] DV = PW'(CHAR_D);

  always_comb begin
    if (g_i == '0) f_o = '0;
    else           f_o = DV - g_i;
  end
endmodule

// File: rtl/gfx_row.sv
`timescale 1ns/1ps
// One row of the array: shift the running sum up one degree, add A*b_j,
// and cancel the digit that left degree m-1 using f times the modulus.
module gfx_row
  import gfx_pkg::*;
#(
  parameter int CHAR_D = 7,
  parameter int DEG_M  = 3,
  localparam int PW = digit_bits(CHAR_D),
  localparam int VW = DEG_M * PW
) (
  input  logic [VW-1:0] acc_i,
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] poly_i,
  input  logic [PW-1:0] bdig_i,
  output logic [VW-1:0] acc_o
);
  logic [PW-1:0] top_dig;
  logic [PW-1:0] fold_f;

  assign top_dig = acc_i[(DEG_M-1)*PW +: PW];

  gfx_neg_digit #(.CHAR_D(CHAR_D)) u_neg (
    .g_i (top_dig),
    .f_o (fold_f)
  );

  for (genvar i = 0; i < DEG_M; i++) begin : g_cell
    logic [PW-1:0] shifted;
    if (i == 0) begin : g_low
      assign shifted = '0;
    end else begin : g_up
      assign shifted = acc_i[(i-1)*PW +: PW];
    end

    gfx_mac_cell #(.CHAR_D(CHAR_D)) u_cell (
      .acc_i (shifted),
      .mx_i  (a_i[i*PW +: PW]),
      .my_i  (bdig_i),
      .rf_i  (fold_f),
      .rp_i  (poly_i[i*PW +: PW]),
      .dig_o (acc_o[i*PW +: PW])
    );
  end
endmodule

// File: rtl/gfx_array_mul.sv
`timescale 1ns/1ps
// GF(CHAR_D^DEG_M) multiplier, polynomial basis, modulus x^DEG_M + POLY_LO.
// Digit i holds the coefficient of x^i (R1). Purely combinational (R7).
module gfx_array_mul
  import gfx_pkg::*;
#(
  parameter int CHAR_D = 7,
  parameter int DEG_M  = 3,
  parameter logic [DEG_M*$clog2(CHAR_D)-1:0] POLY_LO = 9'd5
) (
  input  logic [DEG_M*$clog2(CHAR_D)-1:0] opnd_a,
  input  logic [DEG_M*$clog2(CHAR_D)-1:0] opnd_b,
  output logic [DEG_M*$clog2(CHAR_D)-1:0] prod
);
  localparam int PW = digit_bits(CHAR_D);
  localparam int VW = DEG_M * PW;

  logic [VW-1:0] chain [DEG_M+1];

  assign chain[0] = '0;

  // Row r consumes digit DEG_M-1-r of B, most significant first (Horner order).
  for (genvar r = 0; r < DEG_M; r++) begin : g_row
    gfx_row #(.CHAR_D(CHAR_D), .DEG_M(DEG_M)) u_row (
      .acc_i  (chain[r]),
      .a_i    (opnd_a),
      .poly_i (POLY_LO),
      .bdig_i (opnd_b[(DEG_M-1-r)*PW +: PW]),
      .acc_o  (chain[r+1])
    );
  end

  assign prod = chain[DEG_M];
endmodule

// File: rtl/gfx_array_mul_chk.sv
`timescale 1ns/1ps
module gfx_array_mul_chk
  import gfx_pkg::*;
#(
  parameter int CHAR_D = 7,
  parameter int DEG_M  = 3,
  localparam int PW = digit_bits(CHAR_D),
  localparam int VW = DEG_M * PW
) (
  input logic [VW-1:0] opnd_a,
  input logic [VW-1:0] opnd_b,
  input logic [VW-1:0] prod
);
  function automatic bit digits_ok(input logic [VW-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < DEG_M; i++)
      if (int'(v[i*PW +: PW]) >= CHAR_D) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit is_unit(input logic [VW-1:0] v);
    return v == VW'(1);
  endfunction

  always_comb begin
    if (digits_ok(opnd_a) && digits_ok(opnd_b)) begin
      assert_digit_range_R3: assert (digits_ok(prod))
        else $error("product digit out of range");
      assert_zero_absorbs_R4: assert (!((opnd_a == '0) || (opnd_b == '0)) || (prod == '0))
        else $error("zero operand gave nonzero product");
      assert_right_identity_R5: assert (!is_unit(opnd_b) || (prod == opnd_a))
        else $error("right identity broken");
      assert_left_identity_R5: assert (!is_unit(opnd_a) || (prod == opnd_b))
        else $error("left identity broken");
    end
  end
endmodule

bind gfx_array_mul gfx_array_mul_chk #(.CHAR_D(CHAR_D), .DEG_M(DEG_M)) u_chk (
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .prod   (prod)
);

// File: tb/gfx_array_mul_tb_top.sv
`timescale 1ns/1ps
module gfx_array_mul_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam int P9[3]   = '{1, 0, 0};  // x^2 + 1 over GF(3)
  localparam int P343[3] = '{5, 0, 0};  // x^3 + 5 over GF(7)
  localparam int P125[3] = '{1, 1, 0};  // x^3 + x + 1 over GF(5)

  logic [3:0] a3 = '0, b3 = '0, p3;
  logic [8:0] a7 = '0, b7 = '0, p7;
  logic [8:0] a5 = '0, b5 = '0, p5;

  gfx_array_mul #(.CHAR_D(3), .DEG_M(2), .POLY_LO(4'd1)) u_gf9 (
    .opnd_a(a3), .opnd_b(b3), .prod(p3));
  gfx_array_mul #(.CHAR_D(7), .DEG_M(3), .POLY_LO(9'd5)) dut_i (
    .opnd_a(a7), .opnd_b(b7), .prod(p7));
  gfx_array_mul #(.CHAR_D(5), .DEG_M(3), .POLY_LO(9'd9)) u_gf125 (
    .opnd_a(a5), .opnd_b(b5), .prod(p5));

  function automatic int modd(input int v, input int d);
    int r;
    r = v % d;
    return (r < 0) ? r + d : r;
  endfunction

  function automatic logic [11:0] pack_n(input int n, input int d, input int m);
    logic [11:0] r;
    int pw;
    r = '0;
    pw = $clog2(d);
    for (int i = 0; i < m; i++) begin
      r = r | (12'(n % d) << (i * pw));
      n = n / d;
    end
    return r;
  endfunction

  function automatic logic [11:0] model(input logic [11:0] av, input logic [11:0] bv,
                                        input int d, input int m, input int poly[3]);
    int pw, mask, t;
    int a[3];
    int b[3];
    int c[5];
    logic [11:0] r;
    pw = $clog2(d);
    mask = (1 << pw) - 1;
    r = '0;
    for (int i = 0; i < 3; i++) begin a[i] = 0; b[i] = 0; end
    for (int k = 0; k < 5; k++) c[k] = 0;
    for (int i = 0; i < m; i++) begin
      a[i] = int'(av >> (i * pw)) & mask;
      b[i] = int'(bv >> (i * pw)) & mask;
    end
    for (int i = 0; i < m; i++)
      for (int j = 0; j < m; j++)
        c[i+j] = modd(c[i+j] + a[i] * b[j], d);
    for (int k = 2 * m - 2; k >= m; k--) begin
      t = c[k];
      c[k] = 0;
      for (int i = 0; i < m; i++)
        c[k-m+i] = modd(c[k-m+i] - t * poly[i], d);
    end
    for (int i = 0; i < m; i++) r = r | (12'(c[i]) << (i * pw));
    return r;
  endfunction

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic bit range7_ok(input logic [8:0] v);
    return (v[2:0] < 3'd7) && (v[5:3] < 3'd7) && (v[8:6] < 3'd7);
  endfunction

  initial begin
    #25 rst_n = 1'b1;

    // R4: zero operands after reset give zero
    @(negedge clk); #2;
    check("R4 zero operands", 12'(p7), 12'h0);

    // R1: x * 3 = 3x, digit 1 at bits [5:3]
    @(negedge clk); #2; a7 = 9'd8; b7 = 9'd3;
    #2 check("R1 digit layout", 12'(p7), 12'd24);

    // R6: x^2 * x = x^3 = -5 = 2 in GF(7^3)
    @(negedge clk); #2; a7 = 9'd64; b7 = 9'd8;
    #2 check("R6 fold GF(7^3)", 12'(p7), 12'd2);

    // R6: x^2 * x = -(x+1) = 4x + 4 in GF(5^3)
    @(negedge clk); #2; a5 = 9'd64; b5 = 9'd8;
    #2 check("R6 fold GF(5^3)", 12'(p5), 12'd36);

    // R5: right and left identity
    @(negedge clk); #2; a7 = 9'(pack_n(3 + 5*7 + 6*49, 7, 3)); b7 = 9'd1;
    #2 check("R5 right identity", 12'(p7), 12'(a7));
    @(negedge clk); #2; b7 = a7; a7 = 9'd1;
    #2 check("R5 left identity", 12'(p7), 12'(b7));

    // R4: zero times a full operand
    @(negedge clk); #2; a7 = '0; b7 = 9'd438;
    #2 check("R4 zero absorbs", 12'(p7), 12'h0);

    // R3: all digits at d-1
    @(negedge clk); #2; a7 = 9'd438; b7 = 9'd438;
    #2 check("R3 digit range", {11'b0, range7_ok(p7)}, 12'd1);
    check("R3 value", 12'(p7), model(12'(a7), 12'(b7), 7, 3, P343));

    // R7: operand change inside the high phase, no clock edge before sampling
    @(posedge clk); #3; a7 = 9'(pack_n(200, 7, 3)); b7 = 9'(pack_n(77, 7, 3));
    #1 check("R7 no clock needed", 12'(p7), model(12'(a7), 12'(b7), 7, 3, P343));
    #1 a7 = 9'(pack_n(341, 7, 3));
    #1 check("R7 second change", 12'(p7), model(12'(a7), 12'(b7), 7, 3, P343));

    // R8: GF(3^2) exhaustive
    for (int ia = 0; ia < 9; ia++)
      for (int ib = 0; ib < 9; ib++) begin
        @(negedge clk); #2;
        a3 = 4'(pack_n(ia, 3, 2)); b3 = 4'(pack_n(ib, 3, 2));
        #2 check("R8 GF(3^2)", 12'(p3), model(12'(a3), 12'(b3), 3, 2, P9));
      end

    // R8: GF(5^3) random pairs
    for (int n = 0; n < 1000; n++) begin
      @(negedge clk); #2;
      a5 = 9'(pack_n(int'($urandom_range(0, 124)), 5, 3));
      b5 = 9'(pack_n(int'($urandom_range(0, 124)), 5, 3));
      #2 check("R8 GF(5^3)", 12'(p5), model(12'(a5), 12'(b5), 5, 3, P125));
    end

    // R2: GF(7^3) exhaustive
    for (int ia = 0; ia < 343; ia++)
      for (int ib = 0; ib < 343; ib++) begin
        @(negedge clk); #2;
        a7 = 9'(pack_n(ia, 7, 3)); b7 = 9'(pack_n(ib, 7, 3));
        #2 check("R2 GF(7^3)", 12'(p7), model(12'(a7), 12'(b7), 7, 3, P343));
      end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule